// File: doc/BRIEF.md
# Dataset Staging Controller

This block stages a fixed table of samples through on-chip RAM before they are processed. A run starts with a start pulse. The block first reads every entry of a read-only sample table and stores one lane of each entry into RAM. It raises a write-complete flag once the last store is done. It then reads the RAM back in ascending address order and offers each word to a downstream consumer that may take several cycles per word.

The sample table entries are wider than the RAM words. A lane-select input, sampled when the run is accepted, chooses which slice of each entry is kept. The table and the RAM are synchronous memories outside the block, each with one cycle of read latency. The consumer sees a data word with a valid strobe and answers with an accept (ready) signal. The next RAM read is issued only in the cycle the current word is accepted. A one-cycle done pulse closes the run.

Top module: `dataset_stager`

## Requirements
- R1: While reset is low and in the first cycle after it, `rom_rd_o`, `ram_we_o`, `ram_re_o`, `out_valid_o`, `wr_done_o` and `done_o` are all low.
- R2: After an accepted start, table addresses 0 to DEPTH-1 are read in ascending order, one per cycle. The word read at address a is stored to RAM address a in the following cycle, so exactly DEPTH stores occur per run.
- R3: `mode_i` is sampled only in the cycle the start is accepted. Lane k of a table word is bits [k*OUT_W+OUT_W-1 : k*OUT_W], so with the defaults mode 0 stores bits [31:0] and mode 1 stores bits [63:32]. Changes of `mode_i` during a run have no effect.
- R4: `wr_done_o` rises in the cycle after the final store. It stays high until the next accepted start, and is low in the first table-read cycle of a new run.
- R5: A RAM read is never issued while `wr_done_o` is low, and `ram_we_o` and `ram_re_o` are never high together.
- R6: RAM read-back covers addresses 0 to DEPTH-1 in ascending order, exactly DEPTH reads per run. `out_valid_o` is high in the cycle after each read is issued, and `out_data_o` equals the stored word.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_data_o` hold their values and no RAM read is issued. The next read is issued in the cycle of acceptance.
- R8: `done_o` is high for exactly one cycle, the cycle after the final word is accepted. After that, `out_valid_o` is low and the block is idle.
- R9: A start pulse that arrives during a run is ignored: that run still makes exactly DEPTH stores of the originally selected lane and gives a single done pulse.
- R10: Pulling reset low in the middle of a run returns the block to idle. The next run starts again from table address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Run request pulse, honoured only when idle |
| mode_i | input | SEL_W | Lane select for the stored slice |
| rom_rd_o | output | 1 | Sample table read strobe |
| rom_addr_o | output | AW | Sample table address |
| rom_data_i | input | IN_W | Sample table word, one cycle after the read |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_addr_o | output | AW | RAM address, shared by write and read |
| ram_wdata_o | output | OUT_W | RAM write data (selected lane) |
| ram_rdata_i | input | OUT_W | RAM read data, one cycle after the read |
| out_data_o | output | OUT_W | Word offered to the consumer |
| out_valid_o | output | 1 | Consumer word valid |
| out_ready_i | input | 1 | Consumer accept |
| wr_done_o | output | 1 | All stores finished, held until next start |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The properties take for granted that both memories return data exactly one cycle after a read strobe. They also assume the RAM output stays where it is when no new read is issued. The stall property further assumes that the consumer drops ready only while a word is on offer. The bench keeps to these assumptions: its memory models register their outputs on the strobe alone. Its consumer changes ready just after a clock edge in one of three fixed patterns, so the handshake is stressed without ever violating the one-cycle latency rule.

// File: rtl/stage_pkg.sv
// Shared types for the dataset staging controller.
// Assumes nothing beyond a single clock domain.
package stage_pkg;

    // Run phases of the staging sequencer
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for a start
        PH_COPY  = 2'd1,   // table reads and RAM stores in flight
        PH_ISSUE = 2'd2,   // first RAM read of the read-back
        PH_HOLD  = 2'd3    // word offered to the consumer
    } phase_e;

endpackage

// File: rtl/stage_addr_ctr.sv
// Address counter over 0 .. DEPTH-1 with a last-address flag.
// Assumes DEPTH <= 2**AW. Wraps to zero when stepped at the last address.
module stage_addr_ctr #(
    parameter int AW    = 10,
    parameter int DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [AW-1:0] value_o,
    output logic          last_o
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] value_q;

    // Counter register: clear wins over step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (clr_i) begin
            value_q <= '0;
        end else if (inc_i) begin
            value_q <= (value_q == LAST_ADDR) ? '0 : value_q + AW'(1);
        end
    end

    // Outputs: current value and last-address flag
    always_comb begin
        value_o = value_q;
        last_o  = (value_q == LAST_ADDR);
    end

endmodule

// File: rtl/stage_lane_pick.sv
// Selects one OUT_W-wide lane from an IN_W-wide word.
// Assumes IN_W is a whole multiple of OUT_W; an out-of-range select yields lane 0.
module stage_lane_pick #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 32,
    parameter int SEL_W = 1
) (
    input  logic [IN_W-1:0]  word_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [OUT_W-1:0] lane_o
);

    localparam int LANES = IN_W / OUT_W;

    logic [OUT_W-1:0] lanes [LANES];

    // Slice the wide word into its lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_i[g*OUT_W +: OUT_W];
    end

    // Lane multiplexer
    always_comb begin
        lane_o = lanes[0];
        for (int i = 1; i < LANES; i++) begin
            if (sel_i == SEL_W'(i)) begin
                lane_o = lanes[i];
            end
        end
    end

endmodule

// File: rtl/dataset_stager.sv
// Dataset staging controller: copies DEPTH table entries (one lane each) into
// RAM, flags write-complete, then replays the RAM to a handshaked consumer.
// Assumes synchronous table and RAM with one cycle of read latency, and that
// the RAM output holds while no new read is issued.
module dataset_stager #(
    parameter  int DEPTH = 1024,
    parameter  int AW    = 10,
    parameter  int IN_W  = 64,
    parameter  int OUT_W = 32,
    localparam int LANES = IN_W / OUT_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SEL_W-1:0] mode_i,
    output logic             rom_rd_o,
    output logic [AW-1:0]    rom_addr_o,
    input  logic [IN_W-1:0]  rom_data_i,
    output logic             ram_we_o,
    output logic             ram_re_o,
    output logic [AW-1:0]    ram_addr_o,
    output logic [OUT_W-1:0] ram_wdata_o,
    input  logic [OUT_W-1:0] ram_rdata_i,
    output logic [OUT_W-1:0] out_data_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic             wr_done_o,
    output logic             done_o
);

    import stage_pkg::*;

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    phase_e           phase_q, phase_d;
    logic [SEL_W-1:0] mode_q;
    logic             rd_live_q;
    logic             pend_v_q;
    logic [AW-1:0]    pend_addr_q;
    logic             fresh_q;
    logic [OUT_W-1:0] hold_q;
    logic             wr_done_q;
    logic             done_q;

    logic             start_ok;
    logic             fetch;
    logic             last_store;
    logic             accept;
    logic             step_rd;
    logic [AW-1:0]    fetch_addr;
    logic             fetch_last;
    logic [AW-1:0]    rp_addr;
    logic             rp_last;
    logic [AW-1:0]    rp_next;

    // Control decode from the current phase
    always_comb begin
        start_ok   = start_i && (phase_q == PH_IDLE);
        fetch      = (phase_q == PH_COPY) && rd_live_q;
        last_store = pend_v_q && (pend_addr_q == LAST_ADDR);
        accept     = (phase_q == PH_HOLD) && out_ready_i;
        step_rd    = accept && !rp_last;
        rp_next    = rp_addr + AW'(1);
    end

    // Table read address counter
    stage_addr_ctr #(.AW(AW), .DEPTH(DEPTH)) i_fetch_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_ok),
        .inc_i   (fetch),
        .value_o (fetch_addr),
        .last_o  (fetch_last)
    );

    // Read-back address counter
    stage_addr_ctr #(.AW(AW), .DEPTH(DEPTH)) i_replay_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_ok),
        .inc_i   (step_rd),
        .value_o (rp_addr),
        .last_o  (rp_last)
    );

    // Lane selection on the incoming table word
    stage_lane_pick #(.IN_W(IN_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) i_lane (
        .word_i (rom_data_i),
        .sel_i  (mode_q),
        .lane_o (ram_wdata_o)
    );

    // Next-phase logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start_ok)           phase_d = PH_COPY;
            PH_COPY:  if (last_store)         phase_d = PH_ISSUE;
            PH_ISSUE:                         phase_d = PH_HOLD;
            PH_HOLD:  if (accept && rp_last)  phase_d = PH_IDLE;
            default:                          phase_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Run setup: lane select and table-read enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            rd_live_q <= 1'b0;
        end else if (start_ok) begin
            mode_q    <= mode_i;
            rd_live_q <= 1'b1;
        end else if (fetch && fetch_last) begin
            rd_live_q <= 1'b0;
        end
    end

    // Store stage: remembers which address the table data now arriving belongs to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q    <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            pend_v_q <= fetch;
            if (fetch) pend_addr_q <= fetch_addr;
        end
    end

    // Read-back word capture: fresh marks the cycle RAM data first appears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            fresh_q <= ram_re_o;
            if (fresh_q) hold_q <= ram_rdata_i;
        end
    end

    // Completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_done_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (start_ok)        wr_done_q <= 1'b0;
            else if (last_store) wr_done_q <= 1'b1;
            done_q <= accept && rp_last;
        end
    end

    // Memory-side outputs
    always_comb begin
        rom_rd_o   = fetch;
        rom_addr_o = fetch_addr;
        ram_we_o   = pend_v_q;
        ram_re_o   = (phase_q == PH_ISSUE) || step_rd;
        if (pend_v_q)                 ram_addr_o = pend_addr_q;
        else if (phase_q == PH_HOLD)  ram_addr_o = rp_next;
        else                          ram_addr_o = rp_addr;
    end

    // Consumer-side outputs and flags
    always_comb begin
        out_valid_o = (phase_q == PH_HOLD);
        out_data_o  = fresh_q ? ram_rdata_i : hold_q;
        wr_done_o   = wr_done_q;
        done_o      = done_q;
    end

endmodule

// File: rtl/stage_checks.sv
// Temporal checks for dataset_stager, attached with bind.
// Assumes a reset applied from time zero.
module stage_checks #(
    parameter int AW    = 10,
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             rom_rd_o,
    input logic             ram_we_o,
    input logic             ram_re_o,
    input logic [AW-1:0]    ram_addr_o,
    input logic [OUT_W-1:0] out_data_o,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic             wr_done_o,
    input logic             done_o
);

    a_r5_no_we_re_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we_o && ram_re_o));

    a_r5_read_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re_o |-> wr_done_o);

    a_r2_store_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |=> ram_we_o);

    a_r2_store_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |=> (!ram_we_o || ram_addr_o == AW'($past(ram_addr_o) + AW'(1))));

    a_r6_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re_o |=> out_valid_o);

    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    a_r7_no_read_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |-> !ram_re_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_done_o && !out_valid_o));

    a_r4_wr_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done_o && !start_i) |=> wr_done_o);

endmodule

bind dataset_stager stage_checks #(.AW(AW), .OUT_W(OUT_W)) i_stage_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rom_rd_o    (rom_rd_o),
    .ram_we_o    (ram_we_o),
    .ram_re_o    (ram_re_o),
    .ram_addr_o  (ram_addr_o),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .wr_done_o   (wr_done_o),
    .done_o      (done_o)
);

// File: tb/test_dataset_stager.sv
// Directed bench for dataset_stager: memory models, a consumer with
// selectable ready patterns, and one task per scenario.
module test_dataset_stager;

    localparam int DEPTH = 20;
    localparam int AW    = 5;
    localparam int IN_W  = 64;
    localparam int OUT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [0:0]       mode_i = 1'b0;
    logic             rom_rd_o;
    logic [AW-1:0]    rom_addr_o;
    logic [IN_W-1:0]  rom_data_i;
    logic             ram_we_o;
    logic             ram_re_o;
    logic [AW-1:0]    ram_addr_o;
    logic [OUT_W-1:0] ram_wdata_o;
    logic [OUT_W-1:0] ram_rdata_i;
    logic [OUT_W-1:0] out_data_o;
    logic             out_valid_o;
    logic             out_ready_i = 1'b1;
    logic             wr_done_o;
    logic             done_o;

    dataset_stager #(.DEPTH(DEPTH), .AW(AW), .IN_W(IN_W), .OUT_W(OUT_W)) i_dataset_stager (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
        .ram_we_o(ram_we_o), .ram_re_o(ram_re_o), .ram_addr_o(ram_addr_o),
        .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
        .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .wr_done_o(wr_done_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    function automatic logic [IN_W-1:0] rom_word(input int a);
        return {32'hA5A5_0000 + 32'(a * 3), 32'h0000_C300 + 32'(a)};
    endfunction

    function automatic logic [OUT_W-1:0] lane(input int m, input int a);
        logic [IN_W-1:0] w;
        w = rom_word(a);
        return (m != 0) ? w[63:32] : w[31:0];
    endfunction

    // Memory models: one cycle of read latency
    logic [OUT_W-1:0] ram_mem [1 << AW];
    always @(posedge clk) begin
        if (rom_rd_o) rom_data_i <= rom_word(int'(rom_addr_o));
        if (ram_we_o) ram_mem[ram_addr_o] <= ram_wdata_o;
        if (ram_re_o) ram_rdata_i <= ram_mem[ram_addr_o];
    end

    // Consumer ready patterns, changed just after each rising edge
    int rdy_mode = 0;
    initial begin
        int k;
        k = 0;
        forever begin
            @(posedge clk);
            #1;
            k++;
            case (rdy_mode)
                0:       out_ready_i = 1'b1;
                1:       out_ready_i = (k % 3 == 0);
                default: out_ready_i = (k % 5 == 4);
            endcase
        end
    end

    // Observation log, sampled at the falling edge
    int cyc = 0, exp_mode = 0;
    int rn, wn, rc, on, dn;
    int rom_ord_err, wr_err, out_err, stall_err, overlap, early;
    int first_rom, last_we, wd_rise, first_re, first_valid, last_acc, done_cyc;
    logic wd_at_first_rd, prev_wd = 1'b0, prev_stall = 1'b0;
    logic [OUT_W-1:0] prev_data = '0;

    task automatic clear_log();
        rn = 0; wn = 0; rc = 0; on = 0; dn = 0;
        rom_ord_err = 0; wr_err = 0; out_err = 0; stall_err = 0; overlap = 0; early = 0;
        first_rom = -1; last_we = -1; wd_rise = -1; first_re = -1;
        first_valid = -1; last_acc = -1; done_cyc = -1; wd_at_first_rd = 1'b1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rom_rd_o) begin
            if (int'(rom_addr_o) != rn) rom_ord_err++;
            if (rn == 0) begin
                first_rom = int'(rom_addr_o);
                wd_at_first_rd = wr_done_o;
            end
            rn++;
        end
        if (ram_we_o) begin
            if (int'(ram_addr_o) != wn || ram_wdata_o != lane(exp_mode, wn)) wr_err++;
            wn++;
            last_we = cyc;
        end
        if (wr_done_o && !prev_wd) wd_rise = cyc;
        prev_wd = wr_done_o;
        if (ram_re_o) begin
            if (rc == 0) first_re = cyc;
            rc++;
        end
        if (out_valid_o && first_valid < 0) first_valid = cyc;
        if (prev_stall && (!out_valid_o || out_data_o != prev_data)) stall_err++;
        prev_stall = out_valid_o && !out_ready_i;
        prev_data  = out_data_o;
        if (out_valid_o && out_ready_i) begin
            if (out_data_o != lane(exp_mode, on)) out_err++;
            on++;
            last_acc = cyc;
        end
        if (done_o) begin
            dn++;
            done_cyc = cyc;
        end
        if (ram_we_o && ram_re_o) overlap++;
        if (ram_re_o && !wr_done_o) early++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic outputs_quiet(input string req);
        chk({req, " rom_rd"},  rom_rd_o,    0);
        chk({req, " ram_we"},  ram_we_o,    0);
        chk({req, " ram_re"},  ram_re_o,    0);
        chk({req, " valid"},   out_valid_o, 0);
        chk({req, " wr_done"}, wr_done_o,   0);
        chk({req, " done"},    done_o,      0);
    endtask

    // Launch a run; optionally flip mode and re-pulse start while busy
    task automatic launch(input int mode, input bit poke);
        clear_log();
        exp_mode = mode;
        @(posedge clk); #1;
        start_i = 1'b1; mode_i = 1'(mode);
        @(posedge clk); #1;
        start_i = 1'b0; mode_i = 1'(~mode);      // R3: late mode change
        if (poke) begin
            repeat (3) @(posedge clk);
            #1 start_i = 1'b1;                    // R9: start while busy
            @(posedge clk); #1 start_i = 1'b0;
        end
    endtask

    // Full run with all result checks
    task automatic t_run(input string name, input int mode, input int rmode, input bit poke);
        rdy_mode = rmode;
        launch(mode, poke);
        while (dn == 0) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        $display("scenario %s", name);
        chk("R2 table reads",        rn, DEPTH);
        chk("R2 table order",        rom_ord_err, 0);
        chk("R2 stores",             wn, DEPTH);
        chk("R3 store addr/lane",    wr_err, 0);
        chk("R4 rise after store",   wd_rise - last_we, 1);
        chk("R4 low at first read",  wd_at_first_rd, 0);
        chk("R4 held after run",     wr_done_o, 1);
        chk("R5 we/re overlap",      overlap, 0);
        chk("R5 read before done",   early, 0);
        chk("R6 valid after issue",  first_valid - first_re, 1);
        chk("R6 words delivered",    on, DEPTH);
        chk("R6 word values",        out_err, 0);
        chk("R7 stall hold",         stall_err, 0);
        chk("R7 read count",         rc, DEPTH);
        chk("R8 done count",         dn, 1);
        chk("R8 done timing",        done_cyc - last_acc, 1);
        chk("R8 idle after",         out_valid_o, 0);
        if (poke) begin
            chk("R9 stores unchanged", wn, DEPTH);
            chk("R9 single done",      dn, 1);
        end
    endtask

    task automatic t_reset_idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        outputs_quiet("R1 in reset");
        #1 rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        outputs_quiet("R1 after reset");
    endtask

    task automatic t_reset_midrun();
        rdy_mode = 0;
        launch(1, 1'b0);
        repeat (6) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        outputs_quiet("R10 reset mid-run");
        #1 rst_n = 1'b1;
        t_run("after mid-run reset", 0, 0, 1'b0);
        chk("R10 restart address", first_rom, 0);
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_log();
        t_reset_idle();
        t_run("lane0 free consumer", 0, 0, 1'b0);
        t_run("lane1 slow consumer", 1, 1, 1'b0);
        t_run("lane0 sparse consumer with busy start", 0, 2, 1'b1);
        t_run("lane1 with busy start", 1, 0, 1'b1);
        t_reset_midrun();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule